// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a clocked sequencer placed between a simple request port on the processor side and an external bank of asynchronous static RAM. The bank is built from two narrow devices. Each holds 1024 words of 4 bits. Both share the same address, chip-select and write-enable wires, and each supplies its own nibble of one 8-bit word. The controller drives the address and the two active-low strobes. It owns one side of a shared data bus: it presents an output value and a tri-state enable, and it receives whatever is seen on the bus.

The external parts have no clock, so every analogue timing limit is turned into a whole number of controller clocks and enforced by a down-counting phase timer. The limits covered are address setup, read access, minimum read cycle, write data setup, write data hold, and bus turnaround after a write. A request is taken only while `ready` is high. Completion is signalled by a one-clock `done`; on reads this comes with the captured word.

The bus is released whenever the memory may drive it. This rules out contention on the shared pins.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `ready` is 1, `done` is 0, both strobes `mem_cs_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is accepted only on a clock where `req` and `ready` are both 1. `ready` is 0 from the clock after acceptance until the transaction ends, and `req` raised during that time starts no memory access.
- R3: A write (`req_we` = 1) stores `req_wdata` at `req_addr` in both devices. The device on lane 0 gets bits 3:0 and the device on lane 1 gets bits 7:4.
- R4: A read (`req_we` = 0) returns on `rdata` the word at `req_addr`. Lane 0 supplies bits 3:0 and lane 1 supplies bits 7:4.
- R5: The controller never enables its bus driver while `mem_cs_n` is 0 and `mem_we_n` is 1.
- R6: Read data is sampled at the last clock of a chip-select window of exactly RD_ACCESS clocks. The address is driven for ADDR_SETUP clocks before that window, with the strobes high.
- R7: Two successive read accesses start (chip-select falling) at least RD_CYCLE clocks apart.
- R8: During a write, `mem_we_n` is low for exactly WR_SETUP clocks. Throughout that time `mem_cs_n` is low and the write data is driven.
- R9: After `mem_we_n` rises, the write data stays driven and unchanged for exactly WR_HOLD clocks, with chip-select already released.
- R10: After the bus driver turns off, at least TURN_CYC clocks pass before chip-select falls for a read.
- R11: `done` is high for exactly one clock per accepted request. On a read, `rdata` holds the result during that clock.
- R12: `mem_addr` does not change while `mem_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 8 | Write word |
| ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read word |
| mem_addr | output | 10 | Address to both devices |
| mem_cs_n | output | 1 | Shared chip-select, active low |
| mem_we_n | output | 1 | Shared write-enable, active low |
| mem_dq_o | output | 8 | Value the controller places on the data bus |
| mem_dq_oe | output | 1 | Tri-state enable of the controller's bus driver |
| mem_dq_i | input | 8 | Value seen on the data bus |

## Verification
The bench builds the controller with ADDR_SETUP = 1, RD_ACCESS = 6, RD_CYCLE = 11, WR_SETUP = 3, WR_HOLD = 2 and TURN_CYC = 3. These short values keep every transaction brief. A read cycle of 11 against 1 + 6 + 1 clocks of active phases forces a recovery pad of 3 clocks, and a hold and turnaround of more than one clock each make off-by-one errors in those counters visible. The RAM model places valid data on the bus only in the last clock of the access window, and garbage before that. Capturing even one clock early therefore returns a wrong word.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and constant helpers for the SRAM bus
// controller. Assumes nothing beyond IEEE 1800-2017 constant functions.
package sram_ctrl_pkg;

    // Phases of one memory transaction, in the order they are visited.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_STROBE   = 3'd2,
        ST_CAPTURE  = 3'd3,
        ST_HOLD     = 3'd4,
        ST_RECOVER  = 3'd5
    } ctrl_state_e;

    // Larger of two integers, usable in localparam expressions.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down-counting phase timer.
// Loads a value, counts down to zero and holds there. A value of N-1
// therefore gives a phase of N clocks. Assumes load has priority over counting.
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load on request, else decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Module: transaction sequencer.
// Walks IDLE -> ADDR -> STROBE -> (CAPTURE | HOLD) -> RECOVER -> IDLE.
// Each timed phase lasts a parameter number of clocks, measured by the
// phase timer. Strobes and driver enable are decoded from the registered
// state only, so they change exactly at clock edges.
// Assumes every timing parameter is at least 1.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_SETUP = 1,
    parameter int RD_ACCESS  = 20,
    parameter int RD_CYCLE   = 30,
    parameter int WR_SETUP   = 2,
    parameter int WR_HOLD    = 1,
    parameter int TURN_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_we,
    output logic accept,
    output logic capture,
    output logic ready,
    output logic done,
    output logic cs_n,
    output logic we_n,
    output logic dq_oe
);

    // Padding after a read so that the whole read cycle spans RD_CYCLE clocks.
    localparam int RD_PAD = imax(1, RD_CYCLE - ADDR_SETUP - RD_ACCESS - 1);
    localparam int MAX_PH = imax(imax(imax(ADDR_SETUP, RD_ACCESS), imax(RD_PAD, WR_SETUP)),
                                 imax(WR_HOLD, TURN_CYC));
    localparam int CNT_W  = $clog2(MAX_PH + 1);

    ctrl_state_e      st_q, st_nxt;
    logic             is_wr_q;
    logic             done_set;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next-state logic and timer loads for each phase boundary.
    always_comb begin
        st_nxt   = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_set = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_nxt   = ST_ADDR;
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ADDR_SETUP - 1);
                end
            end
            ST_ADDR: begin
                if (tmr_zero) begin
                    st_nxt   = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = is_wr_q ? CNT_W'(WR_SETUP - 1) : CNT_W'(RD_ACCESS - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    if (is_wr_q) begin
                        st_nxt   = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(WR_HOLD - 1);
                    end else begin
                        st_nxt   = ST_CAPTURE;
                        capture  = 1'b1;
                        done_set = 1'b1;
                    end
                end
            end
            ST_CAPTURE: begin
                st_nxt   = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_PAD - 1);
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    st_nxt   = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                    done_set = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Direction of the current transaction, fixed at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
        end else if (accept) begin
            is_wr_q <= req_we;
        end
    end

    // Completion pulse, one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= done_set;
        end
    end

    // Strobe and driver decode from the registered state.
    always_comb begin
        ready = (st_q == ST_IDLE);
        cs_n  = (st_q != ST_STROBE);
        we_n  = !((st_q == ST_STROBE) && is_wr_q);
        dq_oe = is_wr_q && ((st_q == ST_ADDR) || (st_q == ST_STROBE) || (st_q == ST_HOLD));
    end

endmodule

// File: rtl/sram_lane_io.sv
// Module: per-device data lanes.
// Splits the write word into one nibble per device and reassembles the read
// word from the nibbles on the bus. Lane k covers bits
// [k*LANE_W +: LANE_W]. The read register of each lane loads only on capture.
module sram_lane_io #(
    parameter int LANES  = 2,
    parameter int LANE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANES*LANE_W-1:0] wword,
    input  logic [LANES*LANE_W-1:0] bus_in,
    output logic [LANES*LANE_W-1:0] bus_out,
    output logic [LANES*LANE_W-1:0] rword
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] nib_q;

        // Drive this device's nibble of the write word.
        assign bus_out[k*LANE_W +: LANE_W] = wword[k*LANE_W +: LANE_W];

        // Capture this device's nibble at the end of the access window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q <= '0;
            end else if (capture) begin
                nib_q <= bus_in[k*LANE_W +: LANE_W];
            end
        end

        assign rword[k*LANE_W +: LANE_W] = nib_q;
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
// Module: top of the asynchronous SRAM bus controller.
// Latches one request, sequences the strobes of a bank of LANES devices
// with LANE_W bits each, and returns read data with a done pulse.
// Assumes the bank is asynchronous and that all timing limits have been
// converted to clock counts of at least 1.
module sram_bus_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int LANES      = 2,
    parameter int LANE_W     = 4,
    parameter int ADDR_SETUP = 1,
    parameter int RD_ACCESS  = 20,
    parameter int RD_CYCLE   = 30,
    parameter int WR_SETUP   = 2,
    parameter int WR_HOLD    = 1,
    parameter int TURN_CYC   = 2,
    localparam int DATA_W    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Request latch: address and write word held for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign mem_addr = addr_q;

    sram_seq_fsm #(
        .ADDR_SETUP (ADDR_SETUP),
        .RD_ACCESS  (RD_ACCESS),
        .RD_CYCLE   (RD_CYCLE),
        .WR_SETUP   (WR_SETUP),
        .WR_HOLD    (WR_HOLD),
        .TURN_CYC   (TURN_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_we  (req_we),
        .accept  (accept),
        .capture (capture),
        .ready   (ready),
        .done    (done),
        .cs_n    (mem_cs_n),
        .we_n    (mem_we_n),
        .dq_oe   (mem_dq_oe)
    );

    sram_lane_io #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .wword   (wdata_q),
        .bus_in  (mem_dq_i),
        .bus_out (mem_dq_o),
        .rword   (rdata)
    );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Module: protocol checker bound to sram_bus_ctrl. It observes the ports
// only and keeps one counter for the turnaround window.
module sram_bus_ctrl_chk #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);

    int unsigned quiet_q;

    // Clocks since the bus driver was last enabled, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= 32'hFFFF;
        end else if (mem_dq_oe) begin
            quiet_q <= 0;
        end else if (quiet_q < 32'hFFFF) begin
            quiet_q <= quiet_q + 1;
        end
    end

    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_cs_n && mem_we_n));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_we_n && !mem_dq_oe));

    a_r8_strobe_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && mem_cs_n && $stable(mem_dq_o)));

    a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && !mem_dq_oe) |-> (quiet_q >= TURN_CYC));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_bus_ctrl.sv
// Bench: scoreboard around sram_bus_ctrl with a behavioural two-device RAM.
module test_sram_bus_ctrl;

    localparam int AS = 1, RA = 6, RC = 11, WS = 3, WH = 2, TC = 3;
    localparam logic [7:0] JUNK = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_we = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ready, done;
    logic [7:0] rdata;
    logic [9:0] mem_addr;
    logic       mem_cs_n, mem_we_n, mem_dq_oe;
    logic [7:0] mem_dq_o, mem_dq_i;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    sram_bus_ctrl #(
        .ADDR_SETUP(AS), .RD_ACCESS(RA), .RD_CYCLE(RC),
        .WR_SETUP(WS), .WR_HOLD(WH), .TURN_CYC(TC)
    ) i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Behavioural bank: two nibble-wide devices; valid data only in the
    // last clock of the access window.
    logic [3:0] dev_lo [1024];
    logic [3:0] dev_hi [1024];
    int         rd_run = 0;
    logic       ram_drv;

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) begin
            dev_lo[mem_addr] <= mem_dq_o[3:0];
            dev_hi[mem_addr] <= mem_dq_o[7:4];
        end
        if (!mem_cs_n && mem_we_n) rd_run <= rd_run + 1;
        else                       rd_run <= 0;
    end

    assign ram_drv  = !mem_cs_n && mem_we_n;
    assign mem_dq_i = ram_drv ? ((rd_run >= RA - 1) ? {dev_hi[mem_addr], dev_lo[mem_addr]} : JUNK)
                              : 8'h00;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard queues.
    logic [7:0] exp_mem [1024];
    bit         q_wr   [$];
    logic [7:0] q_data [$];
    logic [9:0] q_addr [$];

    task automatic issue(input bit wr, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
        if (wr) exp_mem[a] = d;
        q_wr.push_back(wr);
        q_data.push_back(exp_mem[a]);
        q_addr.push_back(a);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Port timing monitor and scoreboard consumer, sampled at the falling edge.
    bit   p_cs = 1, p_we = 1, p_done = 0, in_hold = 0, last_rd = 0;
    int   we_len = 0, hold_len = 0, since_oe = 1000, since_cs = 1000, done_len = 0;
    int   conflicts = 0, cs_falls = 0;
    logic [7:0] hold_val = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && ram_drv) conflicts++;
            if (!mem_we_n) we_len++;
            if (mem_we_n && !p_we) begin
                check(we_len == WS, "R8 write strobe width", we_len, WS);
                we_len = 0; in_hold = 1; hold_len = 0; hold_val = mem_dq_o;
            end
            if (in_hold) begin
                if (mem_dq_oe) begin
                    hold_len++;
                    if (mem_dq_o != hold_val) check(0, "R9 hold data", mem_dq_o, hold_val);
                end else begin
                    check(hold_len == WH, "R9 hold length", hold_len, WH);
                    in_hold = 0;
                end
            end
            if (!mem_cs_n && p_cs) begin
                cs_falls++;
                if (!mem_dq_oe) begin
                    check(since_oe >= TC, "R10 turnaround", since_oe, TC);
                    if (last_rd) check(since_cs >= RC, "R7 read spacing", since_cs, RC);
                end
                last_rd = !mem_dq_oe;
                since_cs = 0;
            end
            since_cs++;
            if (mem_dq_oe) since_oe = 0; else since_oe++;
            if (done) begin
                done_len++;
                if (!p_done) begin
                    if (q_wr.size() == 0) begin
                        check(0, "R2 unexpected done", 1, 0);
                    end else begin
                        automatic bit         w = q_wr.pop_front();
                        automatic logic [7:0] d = q_data.pop_front();
                        automatic logic [9:0] a = q_addr.pop_front();
                        if (w) check({dev_hi[a], dev_lo[a]} == d, "R3 stored word",
                                     {dev_hi[a], dev_lo[a]}, d);
                        else   check(rdata == d, "R4/R6 read word", rdata, d);
                    end
                end
            end else if (p_done) begin
                check(done_len == 1, "R11 done width", done_len, 1);
                done_len = 0;
            end
            p_cs = mem_cs_n; p_we = mem_we_n; p_done = done;
        end
    end

    // Watchdog: a hung run is a failure and still reports the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            dev_lo[i] = 4'h0; dev_hi[i] = 4'h0; exp_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: quiet outputs during and just after reset.
        check(ready && !done && mem_cs_n && mem_we_n && !mem_dq_oe, "R1 reset state",
              {ready, done, mem_cs_n, mem_we_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && !done && mem_cs_n && mem_we_n && !mem_dq_oe, "R1 after reset",
              {ready, done, mem_cs_n, mem_we_n, mem_dq_oe}, 5'b10110);

        // R3/R4: writes at boundary addresses and patterns, then reads back.
        issue(1, 10'd0,    8'hA5);
        issue(1, 10'd1023, 8'h5A);
        issue(1, 10'd512,  8'hFF);
        issue(1, 10'd7,    8'h00);
        issue(1, 10'd300,  8'h3C);
        issue(0, 10'd0,    8'h00);
        issue(0, 10'd1023, 8'h00);
        issue(0, 10'd512,  8'h00);
        issue(0, 10'd7,    8'h00);
        issue(0, 10'd300,  8'h00);
        issue(0, 10'd44,   8'h00);
        // Overwrite then read, and back-to-back writes.
        issue(1, 10'd300,  8'h96);
        issue(1, 10'd301,  8'h69);
        issue(0, 10'd300,  8'h00);
        issue(0, 10'd301,  8'h00);

        // R2: req raised while busy starts no extra access.
        begin
            automatic int falls0;
            issue(0, 10'd0, 8'h00);
            falls0 = cs_falls;
            @(negedge clk);
            check(!ready, "R2 busy ready", ready, 0);
            req = 1'b1; req_we = 1'b1; req_addr = 10'd9; req_wdata = 8'h11;
            repeat (3) @(negedge clk);
            req = 1'b0;
            while (!ready) @(negedge clk);
            repeat (4) @(negedge clk);
            check(cs_falls == falls0 + 1, "R2 ignored request", cs_falls, falls0 + 1);
            check({dev_hi[9], dev_lo[9]} == 8'h00, "R2 no write at 9",
                  {dev_hi[9], dev_lo[9]}, 8'h00);
        end

        while (q_wr.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(conflicts == 0, "R5 bus contention cycles", conflicts, 0);
        check(ready && mem_cs_n && !mem_dq_oe, "R1 idle at end", ready, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule